// File: doc/BRIEF.md
# Attribute-Driven Data Cache Controller

This controller sits between a CPU load/store port and the system bus. For each access it decides, from a global cache enable and the two page attribute bits C (cacheable) and B (bufferable), whether the access is served from a direct-mapped line store, sent as a single bus transfer, or posted to an external write buffer. It holds the tag, a valid bit and two dirty bits for each set. It also holds the line data, so read hits complete with no bus traffic.

The CPU raises `req_valid` and holds the address, direction, data and attributes steady until `rsp_valid` pulses. `req_stall` stays high for as long as the access is still pending. The bus side issues single reads, single unbuffered writes and 8-beat line fills, and each beat is completed by `bus_ack`. Posted writes and dirty-line write-backs leave through the `wb_push` port. That port is held off by `wb_full`.

Byte addresses split as follows. Bits [4:2] give the word in the line, bits [8:5] give the set, and bits [31:9] give the tag. Dirty bit 0 covers words 0–3 and dirty bit 1 covers words 4–7.

Top module: `dcache_policy_ctrl`

## Requirements
- R1: With `cache_en`=0 no lookup takes place. The C attribute is ignored, the access is handled as uncached with the given B bit, the stored line data is never returned, and `hit_err` stays low.
- R2: With `cache_en`=1 and C=0 the tag lookup still runs. A miss never starts a line fill. A hit raises `hit_err` while the request is decided, and the access is still served from the bus.
- R3: C=0,B=0: a read is one bus read and a write is one bus write (`bus_write`=1). The CPU stalls until `bus_ack`, and `bus_abort` is returned on `rsp_abort` for both reads and writes.
- R4: C=0,B=1: a read is one abortable bus read. A write is pushed to the write buffer, completes in the cycle the push is accepted, and never reports an abort.
- R5: C=1,B=0: a read hit returns line data in the request cycle with no bus access, and a read miss fills the line. Every write is pushed to the write buffer, and a write hit also updates the line.
- R6: C=1,B=1: reads behave as in R5. A write hit updates the line, sets the dirty bit of its half, and produces neither a bus access nor a push. A write miss is pushed and does not allocate.
- R7: A read miss to a set whose line has any dirty half first pushes the words of the dirty halves only, in ascending order and with the victim's address, then starts the fill.
- R8: A fill issues 8 single-beat reads with `bus_fill`=1 at ascending word addresses from word 0. The line becomes valid only after the last beat.
- R9: A bus abort during a fill ends the fill, returns `rsp_abort`=1 and leaves the line invalid.
- R10: No push is made while `wb_full`=1. An access waiting on a push stays stalled until the buffer accepts it.
- R11: Synchronous `rst` clears all valid and dirty bits and puts the controller in idle, with no bus request in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cache_en | input | 1 | Global cache enable |
| req_valid | input | 1 | CPU access pending |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store data |
| pg_c | input | 1 | Page cacheable attribute |
| pg_b | input | 1 | Page bufferable attribute |
| req_stall | output | 1 | Access still pending |
| rsp_valid | output | 1 | Access completes this cycle |
| rsp_rdata | output | 32 | Load data |
| rsp_abort | output | 1 | Access ended in an external abort |
| hit_err | output | 1 | Lookup hit in a region marked uncached |
| bus_req | output | 1 | Bus transfer request |
| bus_write | output | 1 | Transfer is a write |
| bus_fill | output | 1 | Transfer is a line-fill beat |
| bus_addr | output | 32 | Transfer byte address |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Transfer completes |
| bus_rdata | input | 32 | Read data |
| bus_abort | input | 1 | Transfer aborted (qualified by `bus_ack`) |
| wb_push | output | 1 | Enqueue into the write buffer |
| wb_addr | output | 32 | Enqueued address |
| wb_data | output | 32 | Enqueued data |
| wb_full | input | 1 | Write buffer cannot accept |

## Verification
The assertions check on every cycle the rules that depend only on the current attributes. No push happens while the buffer is full. Fills occur only for cacheable loads with the cache enabled, and their addresses step by one word. Unbuffered bus writes and write aborts occur only in the uncached, unbuffered mode. The hit error occurs only with the cache enabled and C clear. Behaviour that depends on stored state can only be shown by the bench's scenarios. This covers write-back data surviving until eviction, the eviction of only the dirty half, an aborted fill leaving the line invalid so a later lookup misses, a disabled cache returning bus data rather than a stale line, and reset discarding lines.

// File: rtl/dcache_policy_ctrl.sv
module dcache_policy_ctrl #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int SETS       = 16,
  parameter int LINE_WORDS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cache_en,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              pg_c,
  input  logic              pg_b,
  output logic              req_stall,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_abort,
  output logic              hit_err,
  output logic              bus_req,
  output logic              bus_write,
  output logic              bus_fill,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_abort,
  output logic              wb_push,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [DATA_W-1:0] wb_data,
  input  logic              wb_full
);
  localparam int OFF_W = $clog2(LINE_WORDS);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W - 2;
  localparam logic [OFF_W-1:0] LAST = OFF_W'(LINE_WORDS - 1);

  typedef enum logic [2:0] {S_IDLE, S_RD, S_WR, S_EVICT, S_FILL, S_DONE} state_t;

  state_t            state;
  logic [OFF_W-1:0]  cnt;
  logic [DATA_W-1:0] rdata_q;
  logic              abort_q;
  logic [SETS-1:0]   val_q;
  logic [TAG_W-1:0]  tag_q   [SETS];
  logic [1:0]        dirty_q [SETS];
  logic [DATA_W-1:0] mem     [SETS*LINE_WORDS];

  logic [IDX_W-1:0] idx;
  logic [OFF_W-1:0] wrd;
  logic [TAG_W-1:0] tg;
  assign idx = req_addr[OFF_W+2 +: IDX_W];
  assign wrd = req_addr[2 +: OFF_W];
  assign tg  = req_addr[ADDR_W-1 -: TAG_W];

  logic hit, cached, decide, push_w, push_ok, wb_hit, rd_hit, upd_hit;
  logic ev_dirty, ev_go;

  assign hit     = cache_en & val_q[idx] & (tag_q[idx] == tg);
  assign cached  = cache_en & pg_c;
  assign decide  = (state == S_IDLE) & req_valid;
  assign push_w  = decide & req_write & (cached ? (~pg_b | ~hit) : pg_b);
  assign push_ok = push_w & ~wb_full;
  assign wb_hit  = decide & req_write & cached & pg_b & hit;
  assign rd_hit  = decide & ~req_write & cached & hit;
  assign upd_hit = wb_hit | (push_ok & cached & hit);
  assign ev_dirty = dirty_q[idx][cnt[OFF_W-1]];
  assign ev_go    = ~ev_dirty | ~wb_full;

  assign rsp_valid = rd_hit | wb_hit | push_ok | (state == S_DONE);
  assign rsp_rdata = (state == S_DONE) ? rdata_q : mem[{idx, wrd}];
  assign rsp_abort = (state == S_DONE) & abort_q;
  assign req_stall = req_valid & ~rsp_valid;
  assign hit_err   = decide & hit & ~pg_c;

  assign bus_req   = (state == S_RD) | (state == S_WR) | (state == S_FILL);
  assign bus_write = (state == S_WR);
  assign bus_fill  = (state == S_FILL);
  assign bus_addr  = bus_fill ? {tg, idx, cnt, 2'b00} : req_addr;
  assign bus_wdata = req_wdata;

  assign wb_push = push_ok | ((state == S_EVICT) & ev_dirty & ~wb_full);
  assign wb_addr = (state == S_EVICT) ? {tag_q[idx], idx, cnt, 2'b00} : req_addr;
  assign wb_data = (state == S_EVICT) ? mem[{idx, cnt}] : req_wdata;

  always_ff @(posedge clk) begin
    if (state == S_FILL && bus_ack && !bus_abort) mem[{idx, cnt}] <= bus_rdata;
    else if (upd_hit) mem[{idx, wrd}] <= req_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      cnt     <= '0;
      abort_q <= 1'b0;
      rdata_q <= '0;
      val_q   <= '0;
      for (int s = 0; s < SETS; s++) dirty_q[s] <= 2'b00;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          if (wb_hit) dirty_q[idx][wrd[OFF_W-1]] <= 1'b1;
          if (!req_write) begin
            if (!cached) state <= S_RD;
            else if (!hit) begin
              cnt        <= '0;
              val_q[idx] <= 1'b0;
              state      <= (val_q[idx] && dirty_q[idx] != 2'b00) ? S_EVICT : S_FILL;
            end
          end else if (!cached && !pg_b) state <= S_WR;
        end
        S_RD, S_WR: if (bus_ack) begin
          rdata_q <= bus_rdata;
          abort_q <= bus_abort;
          state   <= S_DONE;
        end
        S_EVICT: if (ev_go) begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST) begin
            dirty_q[idx] <= 2'b00;
            state        <= S_FILL;
          end
        end
        S_FILL: if (bus_ack) begin
          if (bus_abort) begin
            abort_q <= 1'b1;
            state   <= S_DONE;
          end else begin
            cnt <= cnt + 1'b1;
            if (cnt == LAST) begin
              val_q[idx]   <= 1'b1;
              tag_q[idx]   <= tg;
              dirty_q[idx] <= 2'b00;
              state        <= S_IDLE;
            end
          end
        end
        default: begin
          abort_q <= 1'b0;
          state   <= S_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/dcache_policy_chk.sv
module dcache_policy_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              cache_en,
  input logic              req_write,
  input logic              pg_c,
  input logic              pg_b,
  input logic              rsp_abort,
  input logic              hit_err,
  input logic              bus_req,
  input logic              bus_write,
  input logic              bus_fill,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_ack,
  input logic              wb_push,
  input logic              wb_full
);
  assert_no_push_full_R10: assert property (@(posedge clk) disable iff (rst)
    wb_push |-> !wb_full);

  assert_fill_cacheable_R2: assert property (@(posedge clk) disable iff (rst)
    bus_fill |-> (cache_en && pg_c && !req_write));

  assert_bus_write_mode_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_write) |-> (!pg_b && !(cache_en && pg_c)));

  assert_write_abort_mode_R4: assert property (@(posedge clk) disable iff (rst)
    (rsp_abort && req_write) |-> (!pg_b && !(cache_en && pg_c)));

  assert_err_scope_R1: assert property (@(posedge clk) disable iff (rst)
    hit_err |-> (cache_en && !pg_c));

  assert_fill_step_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_fill && $past(bus_fill) && $past(bus_ack)) |->
      (bus_addr == $past(bus_addr) + ADDR_W'(4)));

  assert_reset_quiet_R11: assert property (@(posedge clk)
    rst |=> !bus_req);
endmodule

bind dcache_policy_ctrl dcache_policy_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/test_dcache_policy_ctrl.sv
`timescale 1ns/1ps
module test_dcache_policy_ctrl;
  localparam logic [31:0] K = 32'h5A5A_0000;

  logic clk = 0, rst = 1;
  logic cache_en = 0, req_valid = 0, req_write = 0, pg_c = 0, pg_b = 0;
  logic [31:0] req_addr = 0, req_wdata = 0;
  logic req_stall, rsp_valid, rsp_abort, hit_err;
  logic [31:0] rsp_rdata;
  logic bus_req, bus_write, bus_fill, bus_ack = 0, bus_abort = 0;
  logic [31:0] bus_addr, bus_wdata, bus_rdata = 0;
  logic wb_push, wb_full = 0;
  logic [31:0] wb_addr, wb_data;

  dcache_policy_ctrl i_dcache_policy_ctrl (.*);

  always #2.5 clk = ~clk;

  int n_cmp = 0, n_bad = 0, n_single = 0, n_wbfull_push = 0;
  bit err_seen = 0, abort_on = 0, done = 0;
  logic [31:0] abort_addr = 0;
  logic [31:0] exp_d[$]; bit exp_ab[$]; bit exp_cd[$]; string exp_r[$];
  logic [31:0] fillq[$]; logic [31:0] wbaq[$]; logic [31:0] wbdq[$];

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // bus slave: memory reads back addr ^ K
  always @(negedge clk) begin
    #1;
    bus_ack   = bus_req;
    bus_rdata = bus_addr ^ K;
    bus_abort = bus_req && abort_on && (bus_addr == abort_addr);
  end

  // monitor: scoreboard pop and side-channel logging
  always @(negedge clk) begin
    #2;
    if (rsp_valid) begin
      if (exp_d.size() == 0) chk("unexpected response", 1, 0);
      else begin
        automatic logic [31:0] d = exp_d.pop_front();
        automatic bit ab = exp_ab.pop_front();
        automatic bit cd = exp_cd.pop_front();
        automatic string r = exp_r.pop_front();
        chk({r, " abort"}, 32'(rsp_abort), 32'(ab));
        if (cd) chk({r, " data"}, rsp_rdata, d);
      end
    end
    if (bus_fill && bus_ack) fillq.push_back(bus_addr);
    if (bus_req && bus_ack && !bus_fill) n_single++;
    if (wb_push) begin wbaq.push_back(wb_addr); wbdq.push_back(wb_data); end
    if (wb_push && wb_full) n_wbfull_push++;
    if (hit_err) err_seen = 1;
  end

  task automatic acc(input bit en, c, b, w, input logic [31:0] a, d, ed,
                     input bit eab, cd, input string r, output int cyc);
    bit got;
    exp_d.push_back(ed); exp_ab.push_back(eab); exp_cd.push_back(cd); exp_r.push_back(r);
    cache_en = en; pg_c = c; pg_b = b; req_write = w; req_addr = a; req_wdata = d;
    req_valid = 1; cyc = 0;
    do begin
      #2; got = rsp_valid; cyc++;
      @(negedge clk);
    end while (!got);
    req_valid = 0;
  endtask

  task automatic exp_wb(input logic [31:0] a, d, input string r);
    if (wbaq.size() == 0) chk({r, " push missing"}, 0, 1);
    else begin
      chk({r, " push addr"}, wbaq.pop_front(), a);
      chk({r, " push data"}, wbdq.pop_front(), d);
    end
  endtask

  task automatic exp_fill(input logic [31:0] base, input string r);
    chk({r, " fill beats"}, fillq.size(), 8);
    for (int i = 0; i < 8 && i < fillq.size(); i++) chk({r, " fill order"}, fillq[i], base + 32'(4*i));
    fillq.delete();
  endtask

  initial begin
    #(5 * 150000);
    chk("watchdog expired", 1, 0);
    finish_run();
  end

  initial begin
    int cyc, s0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    #2;
    chk("R11 reset stall", 32'(req_stall), 0);
    chk("R11 reset rsp", 32'(rsp_valid), 0);
    chk("R11 reset bus", 32'(bus_req), 0);
    @(negedge clk);

    // R3: uncached unbuffered
    acc(1,0,0,0, 32'h100, 0, 32'h100 ^ K, 0, 1, "R3 read", cyc);
    chk("R3 read stalls", 32'(cyc > 1), 1);
    abort_on = 1; abort_addr = 32'h104;
    acc(1,0,0,0, 32'h104, 0, 0, 1, 0, "R3 read abort", cyc);
    s0 = n_single;
    abort_addr = 32'h10C;
    acc(1,0,0,1, 32'h108, 32'h11, 0, 0, 0, "R3 write", cyc);
    chk("R3 write stalls", 32'(cyc > 1), 1);
    acc(1,0,0,1, 32'h10C, 32'h12, 0, 1, 0, "R3 write abort", cyc);
    chk("R3 bus writes", n_single - s0, 2);
    chk("R3 no push", wbaq.size(), 0);

    // R4: uncached buffered
    abort_addr = 32'h200;
    acc(1,0,1,1, 32'h200, 32'h22, 0, 0, 0, "R4 write", cyc);
    chk("R4 write one cycle", cyc, 1);
    exp_wb(32'h200, 32'h22, "R4");
    abort_addr = 32'h204;
    acc(1,0,1,0, 32'h204, 0, 0, 1, 0, "R4 read abort", cyc);
    abort_on = 0;

    // R10: full buffer holds a buffered write
    fork
      begin wb_full = 1; repeat (4) @(negedge clk); wb_full = 0; end
      acc(1,0,1,1, 32'h208, 32'h33, 0, 0, 0, "R10 write", cyc);
    join
    chk("R10 stall cycles", cyc, 5);
    exp_wb(32'h208, 32'h33, "R10");

    // R5/R8: write-through
    acc(1,1,0,0, 32'h1020, 0, 32'h1020 ^ K, 0, 1, "R5 read miss", cyc);
    exp_fill(32'h1020, "R8");
    s0 = n_single;
    acc(1,1,0,0, 32'h1024, 0, 32'h1024 ^ K, 0, 1, "R5 read hit", cyc);
    chk("R5 hit one cycle", cyc, 1);
    acc(1,1,0,1, 32'h1028, 32'hD1, 0, 0, 0, "R5 write hit", cyc);
    exp_wb(32'h1028, 32'hD1, "R5 write hit");
    acc(1,1,0,0, 32'h1028, 0, 32'hD1, 0, 1, "R5 updated", cyc);
    acc(1,1,0,1, 32'h3000, 32'hE1, 0, 0, 0, "R5 write miss", cyc);
    exp_wb(32'h3000, 32'hE1, "R5 write miss");
    chk("R5 no bus", n_single - s0, 0);
    chk("R5 no fill", fillq.size(), 0);

    // R6: write-back
    acc(1,1,1,1, 32'h1030, 32'hD2, 0, 0, 0, "R6 write hit", cyc);
    chk("R6 hit no push", wbaq.size(), 0);
    acc(1,1,1,0, 32'h1030, 0, 32'hD2, 0, 1, "R6 readback", cyc);
    acc(1,1,1,1, 32'h5000, 32'hE2, 0, 0, 0, "R6 write miss", cyc);
    exp_wb(32'h5000, 32'hE2, "R6 write miss");
    chk("R6 no allocate", fillq.size(), 0);
    chk("R6 no bus", n_single - s0, 0);

    // R2: enabled, page uncached
    err_seen = 0;
    acc(1,0,0,0, 32'h1024, 0, 32'h1024 ^ K, 0, 1, "R2 hit from bus", cyc);
    chk("R2 error flag", 32'(err_seen), 1);
    err_seen = 0;
    acc(1,0,1,0, 32'h7000, 0, 32'h7000 ^ K, 0, 1, "R2 miss", cyc);
    chk("R2 miss no fill", fillq.size(), 0);
    chk("R2 miss no flag", 32'(err_seen), 0);
    acc(1,1,0,0, 32'h7000, 0, 32'h7000 ^ K, 0, 1, "R2 later cached read", cyc);
    exp_fill(32'h7000, "R2 line was not loaded");

    // R1: cache disabled ignores stored dirty data
    err_seen = 0;
    acc(0,1,0,0, 32'h1030, 0, 32'h1030 ^ K, 0, 1, "R1 read", cyc);
    chk("R1 no flag", 32'(err_seen), 0);
    chk("R1 no fill", fillq.size(), 0);

    // R7: evict dirty upper half only, with buffer full at first
    fork
      begin wb_full = 1; repeat (3) @(negedge clk); wb_full = 0; end
      acc(1,1,1,0, 32'h1220, 0, 32'h1220 ^ K, 0, 1, "R7 conflict read", cyc);
    join
    chk("R7 push count", wbaq.size(), 4);
    exp_wb(32'h1030, 32'hD2, "R7 w4");
    exp_wb(32'h1034, 32'h1034 ^ K, "R7 w5");
    exp_wb(32'h1038, 32'h1038 ^ K, "R7 w6");
    exp_wb(32'h103C, 32'h103C ^ K, "R7 w7");
    exp_fill(32'h1220, "R7");
    chk("R10 no push while full", n_wbfull_push, 0);

    // R9: aborted fill leaves line invalid
    abort_on = 1; abort_addr = 32'h2048;
    acc(1,1,0,0, 32'h2040, 0, 0, 1, 0, "R9 fill abort", cyc);
    chk("R9 beats before abort", fillq.size(), 3);
    fillq.delete();
    abort_on = 0; err_seen = 0;
    acc(1,0,0,0, 32'h2040, 0, 32'h2040 ^ K, 0, 1, "R9 probe", cyc);
    chk("R9 line invalid", 32'(err_seen), 0);
    acc(1,1,0,0, 32'h2040, 0, 32'h2040 ^ K, 0, 1, "R9 refill", cyc);
    exp_fill(32'h2040, "R9 refill");

    // R11: reset discards lines
    rst = 1; @(negedge clk); rst = 0; @(negedge clk);
    acc(1,1,0,0, 32'h1220, 0, 32'h1220 ^ K, 0, 1, "R11 after reset", cyc);
    exp_fill(32'h1220, "R11 refill");

    repeat (3) @(negedge clk);
    chk("scoreboard drained", exp_d.size(), 0);
    finish_run();
  end
endmodule